// File: doc/BRIEF.md
# Serial Audio Transmitter (I2S / Left-Justified)

This block turns audio sample words into a two-slot serial stream: one data line carrying the sample bits most significant first, and a word-select line that marks the left and the right slot. It runs on the system clock. An external bit-clock generator supplies a one-cycle strobe, `bit_tick`, for every falling edge of the bit clock. The data line and the word select change only on a clock edge where that strobe is high, so a receiver that samples on the rising bit-clock edge sees stable data. Software or DMA writes sample words into a one-entry holding register. The block takes a word from that register at the start of each slot that needs fresh data.

The sample length, the slot width, the frame format, mono operation, packed (two samples per word) modes and the underrun fill policy are set by static configuration inputs. These inputs change only while the transmitter is disabled. If a slot starts while the holding register is empty, the block reports an underrun and keeps the frame running. It sends either silence or the last word again in place of the missing data. A loopback switch sends the transmitted data back onto the receive data path.

Top module: `i2s_tx`

## Requirements
- R1: A pulse on `cmd_tx_en` sets `tx_enabled` on the next clock, and a pulse on `cmd_tx_dis` clears it. When both arrive in the same cycle, disable wins.
- R2: `hold_ready` is 1 after reset and while the holding register is empty. It drops the clock after a write and rises again on the edge where a slot start takes the word.
- R3: Every slot is sent MSB first. `cfg_len` selects the sample length: 0=32, 1=24, 2=20, 3=18, 4=16, 5=16 packed, 6=8, 7=8 packed. Lengths 16 and 8 use 16-bit and 8-bit slots, and length 32 uses a 32-bit slot.
- R4: For lengths 24, 20 and 18, `cfg_slot_narrow`=1 gives a 24-bit slot and 0 gives a 32-bit slot.
- R5: In unpacked modes the sample is bits [L-1:0] of the word, where L is the sample length. Slot bits after the sample's LSB are sent as 0.
- R6: `ws_out` is 0 for the left slot and 1 for the right slot, starting with a left slot after enable. With `cfg_left_just`=1 the MSB appears on the same `bit_tick` as the word-select change.
- R7: With `cfg_left_just`=0 (I2S), every data bit appears one `bit_tick` later than in left-justified format, so the MSB follows the word-select change by one bit. The first bit after enable is 0.
- R8: Packed 16-bit takes one word per frame: left = bits [15:0], right = bits [31:16]. Packed 8-bit takes one word per frame: left = bits [7:0], right = bits [15:8].
- R9: With `cfg_mono`=1, only the left slot takes a word, and the right slot repeats the left sample.
- R10: A slot start that needs a word while the holding register is empty raises `underrun` for exactly one clock, following that `bit_tick` edge.
- R11: On underrun, `cfg_repeat_prev`=0 sends an all-zero word and 1 resends the last word taken from the holding register (0 if none since reset).
- R12: With `cfg_loop`=1, `rx_sd_o` equals `sd_out`. With `cfg_loop`=0 it equals `rx_sd_in`.
- R13: While disabled, `sd_out` and `ws_out` are 0 from the clock after `tx_enabled` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per falling bit-clock edge |
| cmd_tx_en | input | 1 | Enable command pulse |
| cmd_tx_dis | input | 1 | Disable command pulse |
| cfg_len | input | 3 | Sample length code |
| cfg_slot_narrow | input | 1 | 24-bit slot for 18/20/24-bit lengths |
| cfg_left_just | input | 1 | 1 = left-justified, 0 = I2S |
| cfg_mono | input | 1 | Right slot repeats the left sample |
| cfg_repeat_prev | input | 1 | Underrun fill: 0 zero, 1 last word |
| cfg_loop | input | 1 | Route transmit data to the receive path |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_data | input | HOLD_W | Sample word to write |
| hold_ready | output | 1 | Holding register empty |
| tx_enabled | output | 1 | Transmitter enabled status |
| underrun | output | 1 | One-clock underrun pulse |
| sd_out | output | 1 | Serial data |
| ws_out | output | 1 | Word select |
| rx_sd_in | input | 1 | External receive serial data |
| rx_sd_o | output | 1 | Receive serial data to the receiver |

## Verification
A wrong slot counter or slot-width decode shows up at the ports as a word-select edge that comes early or late, within the first slot after enable. A fault in the packed, mono or underrun selection corrupts the bits of one whole slot. The bench compares every transmitted bit and word-select level against a bit stream it builds independently, for each format and length case. So any such error appears within one frame. Faults in the holding register or the enable state appear on `hold_ready`, `tx_enabled` or the quiet outputs one clock after the command or write that exposes them.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
   localparam int WORD_W = 32;
   localparam int CNT_W  = $clog2(WORD_W);

   typedef enum logic [2:0] {
      LEN_32      = 3'd0,
      LEN_24      = 3'd1,
      LEN_20      = 3'd2,
      LEN_18      = 3'd3,
      LEN_16      = 3'd4,
      LEN_16_PACK = 3'd5,
      LEN_8       = 3'd6,
      LEN_8_PACK  = 3'd7
   } len_code_e;

   // bits per slot for a length code
   function automatic logic [CNT_W:0] slot_width(input len_code_e c, input logic narrow);
      case (c)
         LEN_32:                 return (CNT_W+1)'(32);
         LEN_24, LEN_20, LEN_18: return narrow ? (CNT_W+1)'(24) : (CNT_W+1)'(32);
         LEN_16, LEN_16_PACK:    return (CNT_W+1)'(16);
         default:                return (CNT_W+1)'(8);
      endcase
   endfunction

   // significant bits per sample for a length code
   function automatic logic [CNT_W:0] sample_width(input len_code_e c);
      case (c)
         LEN_32:              return (CNT_W+1)'(32);
         LEN_24:              return (CNT_W+1)'(24);
         LEN_20:              return (CNT_W+1)'(20);
         LEN_18:              return (CNT_W+1)'(18);
         LEN_16, LEN_16_PACK: return (CNT_W+1)'(16);
         default:             return (CNT_W+1)'(8);
      endcase
   endfunction

   function automatic logic is_packed(input len_code_e c);
      return (c == LEN_16_PACK) || (c == LEN_8_PACK);
   endfunction
endpackage

// File: rtl/txh_hold.sv
module txh_hold #(
   parameter int HOLD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [HOLD_W-1:0] wdata,
   input  logic              take,
   output logic              full,
   output logic [HOLD_W-1:0] data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else if (wr) begin
         full <= 1'b1;
         data <= wdata;
      end else if (take) begin
         full <= 1'b0;
      end
   end

   p_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> full);
   p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !wr) |=> !full);
endmodule

// File: rtl/txh_slot_pick.sv
module txh_slot_pick
   import i2s_tx_pkg::*;
#(
   parameter int HOLD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              side,
   input  len_code_e         len,
   input  logic              mono,
   input  logic              repeat_prev,
   input  logic              hold_full,
   input  logic [HOLD_W-1:0] hold_q,
   output logic              take,
   output logic [HOLD_W-1:0] slot_word,
   output logic              underrun
);
   localparam int HALF = HOLD_W / 2;
   localparam int QTR  = HOLD_W / 4;
   localparam int SW   = $clog2(HOLD_W) + 1;

   logic              packed_mode, need, sel_hi;
   logic [HOLD_W-1:0] fw_q, last_q, word_now, src;
   logic [SW-1:0]     shamt;

   assign packed_mode = is_packed(len);
   assign need        = !side || (!packed_mode && !mono);
   assign take        = load && need && hold_full;
   assign word_now    = hold_full ? hold_q : (repeat_prev ? last_q : '0);
   assign src         = need ? word_now : fw_q;
   assign sel_hi      = side && !mono;
   assign shamt       = SW'(HOLD_W) - SW'(sample_width(len));

   always_comb begin
      if (len == LEN_16_PACK)
         slot_word = {(sel_hi ? src[HOLD_W-1:HALF] : src[HALF-1:0]), {HALF{1'b0}}};
      else if (len == LEN_8_PACK)
         slot_word = {(sel_hi ? src[HALF-1:QTR] : src[QTR-1:0]), {(HOLD_W-QTR){1'b0}}};
      else
         slot_word = src << shamt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fw_q     <= '0;
         last_q   <= '0;
         underrun <= 1'b0;
      end else begin
         underrun <= load && need && !hold_full;
         if (load && need) fw_q <= word_now;
         if (take) last_q <= hold_q;
      end
   end

   p_underrun_at_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |-> $past(load));
   p_take_needs_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> hold_full);
endmodule

// File: rtl/txh_serial.sv
module txh_serial #(
   parameter int WORD_W = 32,
   localparam int CNT_W = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic [CNT_W:0]    swidth,
   input  logic              left_just,
   input  logic [WORD_W-1:0] slot_word,
   output logic              load,
   output logic              side_nxt,
   output logic              sd,
   output logic              ws
);
   logic              run_q, side_q, bit_q, lag_q, slot_end;
   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] sh_q;

   assign slot_end = (cnt_q == CNT_W'(swidth - (CNT_W+1)'(1)));
   assign load     = en && tick && (!run_q || slot_end);
   assign side_nxt = run_q && !side_q;
   assign ws       = side_q;
   assign sd       = left_just ? bit_q : lag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         side_q <= 1'b0;
         cnt_q  <= '0;
         sh_q   <= '0;
         bit_q  <= 1'b0;
         lag_q  <= 1'b0;
      end else if (!en) begin
         run_q  <= 1'b0;
         side_q <= 1'b0;
         cnt_q  <= '0;
         sh_q   <= '0;
         bit_q  <= 1'b0;
         lag_q  <= 1'b0;
      end else if (tick) begin
         lag_q <= bit_q;
         if (load) begin
            run_q  <= 1'b1;
            side_q <= side_nxt;
            cnt_q  <= '0;
            sh_q   <= slot_word << 1;
            bit_q  <= slot_word[WORD_W-1];
         end else begin
            cnt_q  <= cnt_q + 1'b1;
            sh_q   <= sh_q << 1;
            bit_q  <= sh_q[WORD_W-1];
         end
      end
   end

   p_cnt_in_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> ({1'b0, cnt_q} < swidth));
   p_ws_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !tick) |=> ($stable(ws) && $stable(sd)));
   p_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && $past(!en)) |-> (!sd && !ws));
endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
   import i2s_tx_pkg::*;
#(
   parameter int HOLD_W  = 32,
   parameter bit LOOP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              cmd_tx_en,
   input  logic              cmd_tx_dis,
   input  logic [2:0]        cfg_len,
   input  logic              cfg_slot_narrow,
   input  logic              cfg_left_just,
   input  logic              cfg_mono,
   input  logic              cfg_repeat_prev,
   input  logic              cfg_loop,
   input  logic              hold_wr,
   input  logic [HOLD_W-1:0] hold_data,
   output logic              hold_ready,
   output logic              tx_enabled,
   output logic              underrun,
   output logic              sd_out,
   output logic              ws_out,
   input  logic              rx_sd_in,
   output logic              rx_sd_o
);
   localparam int CNT_W = $clog2(HOLD_W);

   if (HOLD_W != WORD_W) begin : g_bad_width
      $error("i2s_tx: HOLD_W must equal the 32-bit sample word");
   end

   len_code_e         len;
   logic              en_q, full, take, load, side_nxt;
   logic [HOLD_W-1:0] hold_q, slot_word;
   logic [CNT_W:0]    swidth;

   assign len        = len_code_e'(cfg_len);
   assign swidth     = slot_width(len, cfg_slot_narrow);
   assign hold_ready = !full;
   assign tx_enabled = en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          en_q <= 1'b0;
      else if (cmd_tx_dis) en_q <= 1'b0;
      else if (cmd_tx_en)  en_q <= 1'b1;
   end

   txh_hold #(.HOLD_W(HOLD_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .wr(hold_wr), .wdata(hold_data),
      .take(take), .full(full), .data(hold_q));

   txh_slot_pick #(.HOLD_W(HOLD_W)) u_pick (
      .clk(clk), .rst_n(rst_n), .load(load), .side(side_nxt), .len(len),
      .mono(cfg_mono), .repeat_prev(cfg_repeat_prev), .hold_full(full),
      .hold_q(hold_q), .take(take), .slot_word(slot_word), .underrun(underrun));

   txh_serial #(.WORD_W(HOLD_W)) u_serial (
      .clk(clk), .rst_n(rst_n), .en(en_q), .tick(bit_tick), .swidth(swidth),
      .left_just(cfg_left_just), .slot_word(slot_word), .load(load),
      .side_nxt(side_nxt), .sd(sd_out), .ws(ws_out));

   if (LOOP_EN) begin : g_loop
      assign rx_sd_o = cfg_loop ? sd_out : rx_sd_in;
   end else begin : g_noloop
      logic unused_loop;
      assign unused_loop = cfg_loop;
      assign rx_sd_o     = rx_sd_in;
   end

   p_dis_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_tx_dis |=> !tx_enabled);
   p_en_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_tx_en && !cmd_tx_dis) |=> tx_enabled);
endmodule

// File: tb/test_i2s_tx.sv
`timescale 1ns/1ps
module test_i2s_tx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_tick = 1'b0, cmd_tx_en = 1'b0, cmd_tx_dis = 1'b0;
   logic [2:0]  cfg_len = 3'd0;
   logic        cfg_slot_narrow = 1'b0, cfg_left_just = 1'b0, cfg_mono = 1'b0;
   logic        cfg_repeat_prev = 1'b0, cfg_loop = 1'b0;
   logic        hold_wr = 1'b0;
   logic [31:0] hold_data = '0;
   logic        hold_ready, tx_enabled, underrun, sd_out, ws_out;
   logic        rx_sd_in = 1'b0, rx_sd_o;

   int n_chk = 0, n_fail = 0;
   logic [31:0] wq [0:7];

   always #2.5 clk = ~clk;

   i2s_tx i_i2s_tx (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cmd_tx_en(cmd_tx_en),
      .cmd_tx_dis(cmd_tx_dis), .cfg_len(cfg_len), .cfg_slot_narrow(cfg_slot_narrow),
      .cfg_left_just(cfg_left_just), .cfg_mono(cfg_mono),
      .cfg_repeat_prev(cfg_repeat_prev), .cfg_loop(cfg_loop), .hold_wr(hold_wr),
      .hold_data(hold_data), .hold_ready(hold_ready), .tx_enabled(tx_enabled),
      .underrun(underrun), .sd_out(sd_out), .ws_out(ws_out),
      .rx_sd_in(rx_sd_in), .rx_sd_o(rx_sd_o));

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #1000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual 0 expected 1");
      summary();
      $finish;
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bit_tick = 0; cmd_tx_en = 0; cmd_tx_dis = 0; hold_wr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic do_tick();
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
   endtask

   task automatic write_word(input logic [31:0] w);
      @(negedge clk) begin hold_wr = 1'b1; hold_data = w; end
      @(negedge clk) hold_wr = 1'b0;
   endtask

   task automatic pulse_en();
      @(negedge clk) cmd_tx_en = 1'b1;
      @(negedge clk) cmd_tx_en = 1'b0;
   endtask

   task automatic pulse_dis();
      @(negedge clk) cmd_tx_dis = 1'b1;
      @(negedge clk) cmd_tx_dis = 1'b0;
   endtask

   function automatic int b_len(input logic [2:0] c);
      case (c) 3'd0: return 32; 3'd1: return 24; 3'd2: return 20; 3'd3: return 18;
         3'd4, 3'd5: return 16; default: return 8; endcase
   endfunction

   function automatic int b_slot_w(input logic [2:0] c, input logic nar);
      case (c) 3'd0: return 32; 3'd1, 3'd2, 3'd3: return nar ? 24 : 32;
         3'd4, 3'd5: return 16; default: return 8; endcase
   endfunction

   function automatic logic [31:0] b_slot(input logic [2:0] c, input logic right,
                                          input logic mono, input logic [31:0] w);
      int l;
      l = b_len(c);
      if (c == 3'd5) return (right && !mono) ? {w[31:16], 16'h0} : {w[15:0], 16'h0};
      if (c == 3'd7) return (right && !mono) ? {w[15:8], 24'h0} : {w[7:0], 24'h0};
      return w << (32 - l);
   endfunction

   // one scenario: model the stream, run the design, compare bit by bit
   task automatic run_case(input string tags, input logic [2:0] len, input logic nar,
                           input logic lj, input logic mono, input logic rpt,
                           input int nslots, input int nw, input logic loop);
      logic eb [0:511];
      logic ew [0:511];
      logic [31:0] fw, last, w, sw;
      int width, total, wi, urun_exp, urun_got, mis, ws_mis, loop_mis, first;
      logic exp_sd;
      bit need, pk;
      width = b_slot_w(len, nar);
      total = nslots * width;
      pk = (len == 3'd5) || (len == 3'd7);
      fw = '0; last = '0; wi = 0; urun_exp = 0;
      for (int s = 0; s < nslots; s++) begin
         need = (s % 2 == 0) || (!pk && !mono);
         if (need) begin
            if (wi < nw) begin w = wq[wi]; wi++; last = w; end
            else begin urun_exp++; w = rpt ? last : 32'h0; end
            fw = w;
         end
         sw = b_slot(len, logic'(s % 2), mono, fw);
         for (int j = 0; j < width; j++) begin
            eb[s*width + j] = sw[31-j];
            ew[s*width + j] = logic'(s % 2);
         end
      end
      do_reset();
      cfg_len = len; cfg_slot_narrow = nar; cfg_left_just = lj; cfg_mono = mono;
      cfg_repeat_prev = rpt; cfg_loop = loop; rx_sd_in = 1'b1;
      pulse_en();
      wi = 0; urun_got = 0; mis = 0; ws_mis = 0; loop_mis = 0; first = -1;
      for (int t = 0; t < total; t++) begin
         if (hold_ready && wi < nw) begin write_word(wq[wi]); wi++; end
         do_tick();
         exp_sd = lj ? eb[t] : ((t == 0) ? 1'b0 : eb[t-1]);
         if (sd_out !== exp_sd) begin mis++; if (first < 0) first = t; end
         if (ws_out !== ew[t]) ws_mis++;
         if (underrun === 1'b1) urun_got++;
         if (loop && rx_sd_o !== sd_out) loop_mis++;
      end
      check(mis == 0, tags, $sformatf("data bit mismatches (first at %0d)", first), mis, 0);
      check(ws_mis == 0, "R6", "word-select mismatches", ws_mis, 0);
      check(urun_got == urun_exp, "R10", "underrun pulse count", urun_got, urun_exp);
      if (loop) check(loop_mis == 0, "R12", "loopback mismatches", loop_mis, 0);
      pulse_dis();
   endtask

   task automatic test_reset();
      do_reset();
      check(hold_ready === 1'b1, "R2", "ready after reset", hold_ready, 1);
      check(tx_enabled === 1'b0, "R1", "enabled after reset", tx_enabled, 0);
      check(sd_out === 1'b0 && ws_out === 1'b0, "R13", "outputs after reset",
            {ws_out, sd_out}, 0);
      check(underrun === 1'b0, "R10", "underrun after reset", underrun, 0);
   endtask

   task automatic test_ready();
      do_reset();
      cfg_len = 3'd0; cfg_left_just = 1'b1; cfg_mono = 0; cfg_loop = 0;
      write_word(32'h8000_0000);
      check(hold_ready === 1'b0, "R2", "ready after write", hold_ready, 0);
      pulse_en();
      check(hold_ready === 1'b0, "R2", "ready held until slot start", hold_ready, 0);
      do_tick();
      check(hold_ready === 1'b1, "R2", "ready after slot start", hold_ready, 1);
      check(sd_out === 1'b1, "R3", "MSB first", sd_out, 1);
      pulse_dis();
   endtask

   task automatic test_cmds();
      do_reset();
      cfg_len = 3'd0; cfg_left_just = 1'b1; cfg_loop = 0;
      pulse_en();
      check(tx_enabled === 1'b1, "R1", "enable command", tx_enabled, 1);
      @(negedge clk) begin cmd_tx_en = 1'b1; cmd_tx_dis = 1'b1; end
      @(negedge clk) begin cmd_tx_en = 1'b0; cmd_tx_dis = 1'b0; end
      check(tx_enabled === 1'b0, "R1", "disable wins over enable", tx_enabled, 0);
      pulse_en();
      write_word(32'hFFFF_FFFF);
      do_tick(); do_tick();
      check(sd_out === 1'b1, "R3", "data before disable", sd_out, 1);
      pulse_dis();
      check(tx_enabled === 1'b0, "R1", "disable command", tx_enabled, 0);
      @(negedge clk);
      check(sd_out === 1'b0 && ws_out === 1'b0, "R13", "quiet while disabled",
            {ws_out, sd_out}, 0);
      do_tick();
      check(sd_out === 1'b0, "R13", "tick ignored while disabled", sd_out, 0);
   endtask

   task automatic test_loop_off();
      do_reset();
      cfg_loop = 1'b0;
      rx_sd_in = 1'b1; @(negedge clk);
      check(rx_sd_o === 1'b1, "R12", "external data passes (1)", rx_sd_o, 1);
      rx_sd_in = 1'b0; @(negedge clk);
      check(rx_sd_o === 1'b0, "R12", "external data passes (0)", rx_sd_o, 0);
   endtask

   initial begin
      wq[0] = 32'hA5C3_1E7B; wq[1] = 32'h1234_9ABC; wq[2] = 32'hF00D_8421;
      wq[3] = 32'h0F0F_C3A5; wq[4] = 32'h7E81_5A66; wq[5] = 32'hDEAD_BEEF;
      wq[6] = 32'h0000_FFFF; wq[7] = 32'h8001_0002;
      test_reset();
      test_ready();
      test_cmds();
      test_loop_off();
      run_case("R6 R3",  3'd4, 1'b0, 1'b1, 1'b0, 1'b0, 4, 4, 1'b0);
      run_case("R7 R4",  3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 4, 4, 1'b0);
      run_case("R5 R9",  3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 4, 2, 1'b0);
      run_case("R4 R5",  3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 2, 2, 1'b0);
      run_case("R8",     3'd5, 1'b0, 1'b1, 1'b0, 1'b0, 4, 2, 1'b0);
      run_case("R8 R11", 3'd7, 1'b0, 1'b0, 1'b1, 1'b1, 4, 1, 1'b0);
      run_case("R11 R3", 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4, 2, 1'b1);
      run_case("R3 R7",  3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 4, 4, 1'b0);
      summary();
      $finish;
   end
endmodule